// File: doc/BRIEF.md
# Pointer-Based Data Memory Access Unit

This unit sits beside the execute stage of a small 16-bit processor core and services every indirect data-memory access. It holds two independent 16-bit data pointers, plus a frame base and an 8-bit frame offset that together form a frame pointer. On each request the unit picks the pointer named in the request and forms the effective address. It then reads or writes a 256 x 16 on-chip SRAM in a single clock cycle, as a full word or as one byte lane, and applies the requested step of +1 or -1 to the pointer.

Loads use the pointer as it stands and step it afterwards. Stores step the pointer first and then write through the new value. In frame mode only the offset register moves, so the base register never sees a carry or a borrow. Software reads and writes all four registers through a side port. The SRAM has no reset, so its contents survive a warm reset.

Top module: `dmau_top`

## Requirements
- R1: The data pointers P0 (`req_sel`=0) and P1 (`req_sel`=1) are 16 bits wide and wrap modulo 65536. `req_upd` encodes the step: 0 and 3 mean no change, 1 means +1, 2 means -1.
- R2: On a load (`req_store`=0) the access uses the pointer value before the step, and the step is applied at the same clock edge.
- R3: On a store (`req_store`=1) the pointer is stepped first, and the write goes to the stepped address.
- R4: Frame mode (`req_sel`=2 or 3) addresses (BASE + OFFS) mod 65536. A load uses OFFS before its step, and a store uses OFFS after its step.
- R5: Frame-mode steps change only OFFS, which is 8 bits and wraps modulo 256. BASE changes only through a register write.
- R6: A word access (`req_byte`=0) addresses word EA and is in range when EA < 256. Load data appears on `rd_data` after the request's clock edge and holds until the next load.
- R7: In a byte access (`req_byte`=1), EA[8:1] selects the word and EA[0] selects the lane (0 = low, 1 = high). A byte store writes `req_wdata[7:0]` into that lane and leaves the other byte unchanged. A byte load returns the lane zero-extended.
- R8: An out-of-range access (word EA >= 256, byte EA >= 512) writes nothing and loads zero. The pointer step still happens.
- R9: `reg_addr` selects a register: 0 = P0, 1 = P1, 2 = BASE, 3 = OFFS. `reg_rdata` shows the current value combinationally, with OFFS zero-extended. A write takes effect at the next edge, and OFFS takes `reg_wdata[7:0]`. If a write and an access step hit the same register in the same cycle, the written value wins.
- R10: Reset clears all four registers and `rd_data`, and leaves SRAM contents intact.
- R11: While `req_valid` is low, no pointer changes and no SRAM word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_sel | input | 2 | Pointer choice: 0 P0, 1 P1, 2/3 frame |
| req_store | input | 1 | 1 store, 0 load |
| req_upd | input | 2 | Step: 0/3 none, 1 +1, 2 -1 |
| req_byte | input | 1 | 1 byte access, 0 word access |
| req_wdata | input | 16 | Store data (byte store uses low 8 bits) |
| rd_data | output | 16 | Registered load data |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Selected register value |

## Verification
A software register write and an access-driven pointer step can land in the same cycle. The bench provokes this by raising `reg_we` on the offset register during a frame load that steps the offset. The load must still use the old offset, and the register must read back the written value. A second case writes P1 while a P0 store steps P0, and both updates must be visible afterwards. Around this, sweeps cover every word address and every byte address, including the wrap and out-of-range edges, and compare the results against a memory model kept in the bench.

// File: rtl/dmau_pkg.sv
package dmau_pkg;

    localparam int PTR_W  = 16;
    localparam int OFFS_W = 8;
    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        SEL_P0    = 2'd0,
        SEL_P1    = 2'd1,
        SEL_FRAME = 2'd2,
        SEL_FRM_B = 2'd3
    } ptr_sel_e;

    typedef enum logic [1:0] {
        UPD_NONE = 2'd0,
        UPD_INC  = 2'd1,
        UPD_DEC  = 2'd2,
        UPD_RSVD = 2'd3
    } upd_e;

    typedef enum logic [1:0] {
        RA_P0   = 2'd0,
        RA_P1   = 2'd1,
        RA_BASE = 2'd2,
        RA_OFFS = 2'd3
    } reg_addr_e;

    typedef struct packed {
        ptr_sel_e sel;
        logic     store;
        upd_e     upd;
        logic     bytesz;
    } acc_req_t;

    typedef struct packed {
        logic [PTR_W-1:0]  p0;
        logic [PTR_W-1:0]  p1;
        logic [PTR_W-1:0]  base;
        logic [OFFS_W-1:0] offs;
    } ptr_state_t;

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] v, input upd_e u);
        case (u)
            UPD_INC: step_ptr = v + 1'b1;
            UPD_DEC: step_ptr = v - 1'b1;
            default: step_ptr = v;
        endcase
    endfunction

    function automatic logic is_frame(input ptr_sel_e s);
        is_frame = s[1];
    endfunction

endpackage

// File: rtl/dmau_addr_gen.sv
module dmau_addr_gen
    import dmau_pkg::*;
(
    input  acc_req_t          req,
    input  ptr_state_t        st,
    output logic [PTR_W-1:0]  ea,
    output ptr_state_t        nxt
);

    logic [PTR_W-1:0] cur;
    logic [PTR_W-1:0] stepped;
    logic [PTR_W-1:0] used;

    always_comb begin
        case (req.sel)
            SEL_P0:  cur = st.p0;
            SEL_P1:  cur = st.p1;
            default: cur = {{(PTR_W-OFFS_W){1'b0}}, st.offs};
        endcase
        stepped = step_ptr(cur, req.upd);
        // stores address through the stepped value, loads through the old one
        used = req.store ? stepped : cur;
        if (is_frame(req.sel))
            ea = st.base + {{(PTR_W-OFFS_W){1'b0}}, used[OFFS_W-1:0]};
        else
            ea = used;
        nxt = st;
        case (req.sel)
            SEL_P0:  nxt.p0 = stepped;
            SEL_P1:  nxt.p1 = stepped;
            default: nxt.offs = stepped[OFFS_W-1:0];
        endcase
    end

endmodule

// File: rtl/dmau_ptr_regs.sv
module dmau_ptr_regs
    import dmau_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  ptr_state_t        nxt,
    input  logic              reg_we,
    input  reg_addr_e         reg_addr,
    input  logic [PTR_W-1:0]  reg_wdata,
    output ptr_state_t        st
);

    ptr_state_t d;

    always_comb begin
        d = acc_valid ? nxt : st;
        if (reg_we) begin
            case (reg_addr)
                RA_P0:   d.p0   = reg_wdata;
                RA_P1:   d.p1   = reg_wdata;
                RA_BASE: d.base = reg_wdata;
                default: d.offs = reg_wdata[OFFS_W-1:0];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= d;
    end

    AST_BASE_SW_ONLY: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_addr == RA_BASE) |=> $stable(st.base)); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!acc_valid && !reg_we) |=> ($stable(st.p0) && $stable(st.p1) && $stable(st.offs))); // R11

    AST_SW_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == RA_OFFS) |=> (st.offs == $past(reg_wdata[OFFS_W-1:0]))); // R9

    AST_P0_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && nxt.p0 != st.p0 && !(reg_we && reg_addr == RA_P0))
        |=> ((st.p0 - $past(st.p0)) == 16'h0001 || ($past(st.p0) - st.p0) == 16'h0001)); // R1

endmodule

// File: rtl/dmau_sram.sv
module dmau_sram
    import dmau_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              store,
    input  logic              bytesz,
    input  logic [PTR_W-1:0]  ea,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int IDX_W  = $clog2(DEPTH);
    localparam int LANES  = DATA_W / 8;
    localparam logic [PTR_W:0] WORD_LIM = (PTR_W+1)'(DEPTH);
    localparam logic [PTR_W:0] BYTE_LIM = (PTR_W+1)'(DEPTH * LANES);

    logic [DATA_W-1:0] mem [DEPTH];
    logic              in_range;
    logic [IDX_W-1:0]  idx;
    logic              lane;
    logic [LANES-1:0]  lane_we;
    logic [DATA_W-1:0] lane_wd;
    logic [DATA_W-1:0] word_q;

    assign in_range = bytesz ? ({1'b0, ea} < BYTE_LIM) : ({1'b0, ea} < WORD_LIM);
    assign idx      = bytesz ? ea[IDX_W:1] : ea[IDX_W-1:0];
    assign lane     = ea[0];
    assign word_q   = mem[idx];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_we[l] = acc_valid && store && in_range && (!bytesz || lane == l[0]);
        assign lane_wd[8*l +: 8] = bytesz ? wdata[7:0] : wdata[8*l +: 8];
    end

    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (lane_we[l]) mem[idx][8*l +: 8] <= lane_wd[8*l +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (acc_valid && !store) begin
            if (!in_range)   rdata <= '0;
            else if (bytesz) rdata <= {8'h00, lane ? word_q[15:8] : word_q[7:0]};
            else             rdata <= word_q;
        end
    end

    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !store && !in_range) |=> (rdata == '0)); // R8

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(acc_valid && !store) |=> $stable(rdata)); // R6

    AST_BYTE_READ_ZEXT: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !store && bytesz) |=> (rdata[15:8] == 8'h00)); // R7

endmodule

// File: rtl/dmau_top.sv
module dmau_top
    import dmau_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [1:0]  req_sel,
    input  logic        req_store,
    input  logic [1:0]  req_upd,
    input  logic        req_byte,
    input  logic [15:0] req_wdata,
    output logic [15:0] rd_data,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata
);

    acc_req_t         req;
    ptr_state_t       st;
    ptr_state_t       nxt;
    logic [PTR_W-1:0] ea;

    assign req.sel    = ptr_sel_e'(req_sel);
    assign req.store  = req_store;
    assign req.upd    = upd_e'(req_upd);
    assign req.bytesz = req_byte;

    dmau_addr_gen u_agen (
        .req (req),
        .st  (st),
        .ea  (ea),
        .nxt (nxt)
    );

    dmau_ptr_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (req_valid),
        .nxt       (nxt),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr_e'(reg_addr)),
        .reg_wdata (reg_wdata),
        .st        (st)
    );

    dmau_sram #(.DEPTH(DEPTH)) u_mem (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (req_valid),
        .store     (req_store),
        .bytesz    (req_byte),
        .ea        (ea),
        .wdata     (req_wdata),
        .rdata     (rd_data)
    );

    always_comb begin
        case (reg_addr_e'(reg_addr))
            RA_P0:   reg_rdata = st.p0;
            RA_P1:   reg_rdata = st.p1;
            RA_BASE: reg_rdata = st.base;
            default: reg_rdata = {{(PTR_W-OFFS_W){1'b0}}, st.offs};
        endcase
    end

endmodule

// File: tb/tb_dmau_top.sv
`timescale 1ns/1ps
module tb_dmau_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_sel = 2'd0;
    logic        req_store = 1'b0;
    logic [1:0]  req_upd = 2'd0;
    logic        req_byte = 1'b0;
    logic [15:0] req_wdata = 16'h0;
    logic [15:0] rd_data;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;

    int nchk = 0;
    int nfail = 0;

    logic [15:0] mdl [256];
    logic [15:0] m_p0 = 16'h0, m_p1 = 16'h0, m_bp = 16'h0;
    logic [7:0]  m_offs = 8'h0;

    always #2.5 clk = ~clk;

    dmau_top dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_sel(req_sel),
        .req_store(req_store), .req_upd(req_upd), .req_byte(req_byte),
        .req_wdata(req_wdata), .rd_data(rd_data), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        reg_addr = 2'd0; #0.2; chk({tag, " P0"}, reg_rdata, m_p0);
        reg_addr = 2'd1; #0.2; chk({tag, " P1"}, reg_rdata, m_p1);
        reg_addr = 2'd2; #0.2; chk({tag, " BASE"}, reg_rdata, m_bp);
        reg_addr = 2'd3; #0.2; chk({tag, " OFFS"}, reg_rdata, {8'h00, m_offs});
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        case (a)
            2'd0: m_p0 = v;
            2'd1: m_p1 = v;
            2'd2: m_bp = v;
            default: m_offs = v[7:0];
        endcase
        @(posedge clk); #0.5;
        reg_we = 1'b0;
    endtask

    // reference behaviour derived from R1..R8; returns expected load data
    task automatic model(input logic [1:0] sel, input logic st, input logic [1:0] upd,
                         input logic b, input logic [15:0] wd, output logic [15:0] exp);
        logic [15:0] cur, md, bv, ea;
        logic ok;
        cur = (sel == 2'd0) ? m_p0 : (sel == 2'd1) ? m_p1 : {8'h00, m_offs};
        md  = (upd == 2'd1) ? cur + 16'd1 : (upd == 2'd2) ? cur - 16'd1 : cur;
        bv  = st ? md : cur;
        ea  = sel[1] ? m_bp + {8'h00, bv[7:0]} : bv;
        ok  = b ? (ea < 16'd512) : (ea < 16'd256);
        if (st && ok) begin
            if (!b)        mdl[ea[7:0]] = wd;
            else if (ea[0]) mdl[ea[8:1]][15:8] = wd[7:0];
            else            mdl[ea[8:1]][7:0]  = wd[7:0];
        end
        if (!ok)        exp = 16'h0;
        else if (!b)    exp = mdl[ea[7:0]];
        else if (ea[0]) exp = {8'h00, mdl[ea[8:1]][15:8]};
        else            exp = {8'h00, mdl[ea[8:1]][7:0]};
        if (sel == 2'd0)      m_p0 = md;
        else if (sel == 2'd1) m_p1 = md;
        else                  m_offs = md[7:0];
    endtask

    task automatic access(input string tag, input logic [1:0] sel, input logic st,
                          input logic [1:0] upd, input logic b, input logic [15:0] wd);
        logic [15:0] exp;
        @(negedge clk);
        req_valid = 1'b1; req_sel = sel; req_store = st; req_upd = upd;
        req_byte = b; req_wdata = wd;
        model(sel, st, upd, b, wd, exp);
        @(posedge clk); #0.5;
        req_valid = 1'b0;
        if (!st) chk({tag, " rd"}, rd_data, exp);
        check_regs(tag);
    endtask

    initial begin
        #(5.0 * 190000);
        nfail++;
        $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        logic [15:0] e;
        repeat (3) @(posedge clk);
        #0.5;
        rst = 1'b0;
        // R10 reset state
        chk("R10 rd", rd_data, 16'h0);
        check_regs("R10");

        // R3 / R1: store sweep with pre-increment from 0xFFFF
        wr(2'd0, 16'hFFFF);
        for (int i = 0; i < 256; i++)
            access("R3", 2'd0, 1'b1, 2'd1, 1'b0, 16'((i * 16'h9E37) ^ 16'h5A5A));
        // R2 / R6: load sweep with post-increment
        wr(2'd1, 16'h0000);
        for (int i = 0; i < 256; i++)
            access("R2", 2'd1, 1'b0, 2'd1, 1'b0, 16'h0);
        access("R8", 2'd1, 1'b0, 2'd1, 1'b0, 16'h0);
        wr(2'd1, 16'd5);
        access("R2", 2'd1, 1'b0, 2'd2, 1'b0, 16'h0);
        wr(2'd0, 16'd10);
        access("R3", 2'd0, 1'b1, 2'd2, 1'b0, 16'hC0DE);
        wr(2'd1, 16'd9);
        access("R3", 2'd1, 1'b0, 2'd0, 1'b0, 16'h0);
        wr(2'd1, 16'd0);
        access("R1", 2'd1, 1'b0, 2'd2, 1'b0, 16'h0);
        access("R1", 2'd1, 1'b0, 2'd3, 1'b0, 16'h0);

        // R5 / R4 frame mode
        wr(2'd2, 16'h0040); wr(2'd3, 16'h00FE);
        for (int i = 0; i < 3; i++) access("R5", 2'd2, 1'b0, 2'd1, 1'b0, 16'h0);
        wr(2'd2, 16'h0030); wr(2'd3, 16'h000F);
        access("R4", 2'd3, 1'b1, 2'd1, 1'b0, 16'hBEEF);
        access("R4", 2'd2, 1'b0, 2'd2, 1'b0, 16'h0);
        access("R4", 2'd2, 1'b1, 2'd2, 1'b0, 16'h1234);
        wr(2'd1, 16'h003E);
        access("R4", 2'd1, 1'b0, 2'd0, 1'b0, 16'h0);
        wr(2'd2, 16'hFFF0); wr(2'd3, 16'h0015);
        access("R4", 2'd2, 1'b0, 2'd0, 1'b0, 16'h0);
        wr(2'd3, 16'h0000);
        access("R5", 2'd2, 1'b1, 2'd2, 1'b0, 16'h7E57);
        wr(2'd1, 16'h00EF);
        access("R5", 2'd1, 1'b0, 2'd0, 1'b0, 16'h0);

        // R7 byte reads over every byte address, then one beyond
        wr(2'd1, 16'h0000);
        for (int i = 0; i < 512; i++) access("R7", 2'd1, 1'b0, 2'd1, 1'b1, 16'h0);
        access("R8", 2'd1, 1'b0, 2'd1, 1'b1, 16'h0);
        // R7 byte writes, read back as words
        wr(2'd0, 16'h001F);
        for (int i = 0; i < 16; i++)
            access("R7", 2'd0, 1'b1, 2'd1, 1'b1, 16'((i * 37) | 16'hA500));
        wr(2'd1, 16'h0010);
        for (int i = 0; i < 8; i++) access("R7", 2'd1, 1'b0, 2'd1, 1'b0, 16'h0);

        // R8 out-of-range stores must not alias
        wr(2'd0, 16'h0100);
        access("R8", 2'd0, 1'b1, 2'd0, 1'b0, 16'hDEAD);
        wr(2'd0, 16'h0200);
        access("R8", 2'd0, 1'b1, 2'd0, 1'b1, 16'h00EE);
        wr(2'd1, 16'h0000);
        access("R8", 2'd1, 1'b0, 2'd0, 1'b0, 16'h0);

        // R11 request fields without valid
        wr(2'd0, 16'h0050);
        @(negedge clk);
        req_valid = 1'b0; req_sel = 2'd0; req_store = 1'b1; req_upd = 2'd1;
        req_byte = 1'b0; req_wdata = 16'hFACE;
        @(posedge clk); #0.5;
        check_regs("R11");
        wr(2'd1, 16'h0051);
        access("R11", 2'd1, 1'b0, 2'd0, 1'b0, 16'h0);

        // R9 register write collides with an access step
        wr(2'd2, 16'h0000); wr(2'd3, 16'h0020);
        @(negedge clk);
        req_valid = 1'b1; req_sel = 2'd2; req_store = 1'b0; req_upd = 2'd1; req_byte = 1'b0;
        reg_we = 1'b1; reg_addr = 2'd3; reg_wdata = 16'h0077;
        model(2'd2, 1'b0, 2'd1, 1'b0, 16'h0, e);
        m_offs = 8'h77;
        @(posedge clk); #0.5;
        req_valid = 1'b0; reg_we = 1'b0;
        chk("R9 rd", rd_data, e);
        check_regs("R9");
        @(negedge clk);
        req_valid = 1'b1; req_sel = 2'd0; req_store = 1'b1; req_upd = 2'd1; req_wdata = 16'h4242;
        reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h0051;
        model(2'd0, 1'b1, 2'd1, 1'b0, 16'h4242, e);
        m_p1 = 16'h0051;
        @(posedge clk); #0.5;
        req_valid = 1'b0; reg_we = 1'b0;
        check_regs("R9");
        access("R9", 2'd1, 1'b0, 2'd0, 1'b0, 16'h0);
        wr(2'd3, 16'hABCD);
        check_regs("R9");

        // R10 warm reset keeps SRAM
        @(negedge clk); rst = 1'b1;
        repeat (2) @(posedge clk);
        #0.5; rst = 1'b0;
        m_p0 = 16'h0; m_p1 = 16'h0; m_bp = 16'h0; m_offs = 8'h0;
        chk("R10 rd", rd_data, 16'h0);
        check_regs("R10");
        wr(2'd1, 16'd9);
        access("R10", 2'd1, 1'b0, 2'd0, 1'b0, 16'h0);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule